// File: doc/BRIEF.md
# ALU Status Flag Generator

This block sits beside an integer adder of a 16-bit processor core. It forms the result of an add, add-with-carry, subtract, subtract-with-borrow, bitwise AND/OR/XOR or counter decrement on two operands, in either a 16-bit or an 8-bit width. It keeps a flag register that holds six status bits (carry, parity, nibble carry, zero, sign, overflow) and three control bits (single-step trap, interrupt enable, string direction).

The result is combinational from the operand inputs. The flag register updates on the rising clock edge. Status bits are written only when the update enable is high and the operation is not a counter decrement. The decrement exists so that a loop counter can be stepped without disturbing any flag. The control bits change only through an explicit write command that names one of them and gives its new value.

Top module: `alu_flag_unit`

## Requirements
- R1: `result` is combinational from the inputs. `opCode` encoding: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 decrement (`opA` minus one). With `wideMode`=1 the operation is 16 bits wide. With `wideMode`=0 only bits 7:0 take part, and `result[15:8]` is zero.
- R2: After an arithmetic update, CF is the carry out of the top bit of the active width for add/adc. For sub/sbb it is the borrow into that bit. `carryIn` is added by adc and subtracted by sbb, and ignored by the other operations.
- R3: After an arithmetic update, AF is the carry out of bit 3 (add/adc) or the borrow into bit 3 (sub/sbb).
- R4: After an arithmetic update, OF is set when the true signed result lies outside the signed range of the active width (bit 15 or bit 7 is the sign).
- R5: After any update, SF is the top bit of the active-width result, and ZF is set when the active-width result is zero.
- R6: After any update, PF is set when `result[7:0]` holds an even number of ones, whatever the width.
- R7: After a logic operation with update, CF and OF are 0 and AF keeps its prior value.
- R8: A decrement (`opCode`=7) leaves all nine flags unchanged, even with `updateEn`=1.
- R9: With `updateEn`=0 the six status flags keep their values.
- R10: When `ctlWr`=1, the control bit chosen by `ctlSel` takes `ctlVal` at the clock edge. `ctlSel` encoding: 0 trap, 1 interrupt enable, 2 direction, 3 none. No arithmetic or logic operation changes a control bit.
- R11: An active-low asynchronous reset clears all flags. `flagsOut` layout: bit0 CF, bit1 PF, bit2 AF, bit3 ZF, bit4 SF, bit5 OF, bit6 trap, bit7 interrupt enable, bit8 direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| opCode | input | 3 | Operation select |
| wideMode | input | 1 | 1: 16-bit, 0: 8-bit |
| carryIn | input | 1 | Carry/borrow input for adc and sbb |
| updateEn | input | 1 | Allow the status flags to be written |
| ctlWr | input | 1 | Write one control bit |
| ctlSel | input | 2 | Control bit select |
| ctlVal | input | 1 | New control bit value |
| result | output | 16 | Operation result |
| flagsOut | output | 9 | Flag register |

## Verification
The bench aims at the sign and carry boundaries: 0x7FFF+1 and 0x8000-1 in word mode, and 0x7F+1 and 0xFF+1 in byte mode. A design that took the sign or carry from the wrong bit for the selected width would report OF, SF and CF wrongly on exactly these values. It also applies results such as 0x0100, whose upper byte has odd parity while the low byte is zero; a design that computed parity over all 16 bits would show PF clear there. It checks that a decrement leaves the flags intact, that a logic operation keeps a previously set AF, and that the carry input is honoured only by adc and sbb. A design that got any of these wrong would lose or corrupt state that a later instruction relies on.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_DEC = 3'd7
  } aluOp_e;

  localparam int FLAG_N = 9;
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_AF = 2;
  localparam int FLG_ZF = 3;
  localparam int FLG_SF = 4;
  localparam int FLG_OF = 5;
  localparam int FLG_TF = 6;
  localparam int FLG_IF = 7;
  localparam int FLG_DF = 8;
  localparam int STATUS_N = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic       arithWr;
    logic       isSub;
    logic       useCarry;
    logic       isLogic;
    logic [1:0] logicSel;
    logic       isDec;
    logic       wrTf;
    logic       wrIf;
    logic       wrDf;
    logic       ctlVal;
  } flagStrb_t;

endpackage

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic [2:0] opCode,
  input  logic       updateEn,
  input  logic       ctlWr,
  input  logic [1:0] ctlSel,
  input  logic       ctlVal,
  output flagStrb_t  strb
);

  aluOp_e opDec;

  always_comb begin
    opDec = aluOp_e'(opCode);
    strb = '0;
    strb.isDec    = (opDec == OP_DEC);
    strb.isLogic  = (opDec == OP_AND) || (opDec == OP_OR) || (opDec == OP_XOR);
    strb.isSub    = (opDec == OP_SUB) || (opDec == OP_SBB) || (opDec == OP_DEC);
    strb.useCarry = (opDec == OP_ADC) || (opDec == OP_SBB);
    strb.logicSel = opCode[1:0];
    strb.arithWr  = updateEn && (opDec != OP_DEC);
    strb.wrTf     = ctlWr && (ctlSel == 2'd0);
    strb.wrIf     = ctlWr && (ctlSel == 2'd1);
    strb.wrDf     = ctlWr && (ctlSel == 2'd2);
    strb.ctlVal   = ctlVal;
  end

endmodule

// File: rtl/alu_flag_dpath.sv
module alu_flag_dpath
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              wideMode,
  input  logic              carryIn,
  input  flagStrb_t         strb,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_N-1:0] flagsQ
);

  localparam int HI_W = DATA_W - BYTE_W;

  logic              cIn;
  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   wExt;
  logic [BYTE_W:0]   bExt;
  logic [NIB_W:0]    nExt;
  logic [DATA_W-1:0] logicRes;
  logic [BYTE_W-1:0] lowRes;
  logic              signA, signB, signR;
  logic              cfNew, afNew, ofNew, zfNew, sfNew, pfNew;

  // adder lanes: full width, low byte, low nibble
  always_comb begin
    cIn  = strb.useCarry & carryIn;
    bEff = strb.isDec ? DATA_W'(1) : opB;
    if (strb.isSub) begin
      wExt = {1'b0, opA} - {1'b0, bEff} - {{DATA_W{1'b0}}, cIn};
      bExt = {1'b0, opA[BYTE_W-1:0]} - {1'b0, bEff[BYTE_W-1:0]} - {{BYTE_W{1'b0}}, cIn};
      nExt = {1'b0, opA[NIB_W-1:0]} - {1'b0, bEff[NIB_W-1:0]} - {{NIB_W{1'b0}}, cIn};
    end else begin
      wExt = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, cIn};
      bExt = {1'b0, opA[BYTE_W-1:0]} + {1'b0, bEff[BYTE_W-1:0]} + {{BYTE_W{1'b0}}, cIn};
      nExt = {1'b0, opA[NIB_W-1:0]} + {1'b0, bEff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cIn};
    end
  end

  always_comb begin
    case (strb.logicSel)
      2'd0:    logicRes = opA & opB;
      2'd1:    logicRes = opA | opB;
      default: logicRes = opA ^ opB;
    endcase
  end

  // width variant of the result lane
  generate
    if (HI_W > 0) begin : gSplit
      always_comb begin
        lowRes = strb.isLogic ? logicRes[BYTE_W-1:0] : bExt[BYTE_W-1:0];
        if (wideMode)
          result = strb.isLogic ? logicRes : wExt[DATA_W-1:0];
        else
          result = {{HI_W{1'b0}}, lowRes};
      end
    end else begin : gFlat
      always_comb begin
        lowRes = strb.isLogic ? logicRes[BYTE_W-1:0] : bExt[BYTE_W-1:0];
        result = lowRes;
      end
    end
  endgenerate

  always_comb begin
    signA = wideMode ? opA[DATA_W-1]    : opA[BYTE_W-1];
    signB = wideMode ? bEff[DATA_W-1]   : bEff[BYTE_W-1];
    signR = wideMode ? result[DATA_W-1] : result[BYTE_W-1];
    cfNew = wideMode ? wExt[DATA_W] : bExt[BYTE_W];
    afNew = nExt[NIB_W];
    if (strb.isSub)
      ofNew = (signA != signB) && (signR != signA);
    else
      ofNew = (signA == signB) && (signR != signA);
    zfNew = (result == '0);
    sfNew = signR;
    pfNew = ~^result[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagsQ <= '0;
    end else begin
      if (strb.arithWr) begin
        flagsQ[FLG_CF] <= strb.isLogic ? 1'b0 : cfNew;
        flagsQ[FLG_OF] <= strb.isLogic ? 1'b0 : ofNew;
        if (!strb.isLogic)
          flagsQ[FLG_AF] <= afNew;
        flagsQ[FLG_ZF] <= zfNew;
        flagsQ[FLG_SF] <= sfNew;
        flagsQ[FLG_PF] <= pfNew;
      end
      if (strb.wrTf) flagsQ[FLG_TF] <= strb.ctlVal;
      if (strb.wrIf) flagsQ[FLG_IF] <= strb.ctlVal;
      if (strb.wrDf) flagsQ[FLG_DF] <= strb.ctlVal;
    end
  end

  AST_TF_CMD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrTf |=> $stable(flagsQ[FLG_TF])); // R10
  AST_IF_CMD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrIf |=> $stable(flagsQ[FLG_IF])); // R10
  AST_DF_CMD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrDf |=> $stable(flagsQ[FLG_DF])); // R10
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.arithWr && strb.isLogic) |=> (!flagsQ[FLG_CF] && !flagsQ[FLG_OF])); // R7
  AST_LOGIC_KEEPS_AF: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.arithWr && strb.isLogic) |=> $stable(flagsQ[FLG_AF])); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.arithWr |=> $stable(flagsQ[STATUS_N-1:0])); // R9

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        opCode,
  input  logic              wideMode,
  input  logic              carryIn,
  input  logic              updateEn,
  input  logic              ctlWr,
  input  logic [1:0]        ctlSel,
  input  logic              ctlVal,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_N-1:0] flagsOut
);

  flagStrb_t strb;

  alu_flag_ctrl uCtrl (
    .opCode   (opCode),
    .updateEn (updateEn),
    .ctlWr    (ctlWr),
    .ctlSel   (ctlSel),
    .ctlVal   (ctlVal),
    .strb     (strb)
  );

  alu_flag_dpath #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .NIB_W  (NIB_W)
  ) uDpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .opA      (opA),
    .opB      (opB),
    .wideMode (wideMode),
    .carryIn  (carryIn),
    .strb     (strb),
    .result   (result),
    .flagsQ   (flagsOut)
  );

  AST_DEC_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 3'd7) |=> $stable(flagsOut)); // R8
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wideMode |-> (result[DATA_W-1:BYTE_W] == '0)); // R1
  AST_PARITY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (updateEn && opCode != 3'd7) |=> (flagsOut[FLG_PF] == ~^$past(result[BYTE_W-1:0]))); // R6

endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;

  localparam int CLK_P = 10;
  localparam logic [2:0] ADD = 3'd0, ADC = 3'd1, SUB = 3'd2, SBB = 3'd3;
  localparam logic [2:0] AND_ = 3'd4, OR_ = 3'd5, XOR_ = 3'd6, DEC = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] opA, opB;
  logic [2:0]  opCode;
  logic        wideMode, carryIn, updateEn, ctlWr, ctlVal;
  logic [1:0]  ctlSel;
  logic [15:0] result;
  logic [8:0]  flagsOut;

  int checks = 0;
  int failures = 0;
  logic [8:0] expFlags;
  bit finished = 0;

  alu_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .opA(opA), .opB(opB), .opCode(opCode),
    .wideMode(wideMode), .carryIn(carryIn), .updateEn(updateEn),
    .ctlWr(ctlWr), .ctlSel(ctlSel), .ctlVal(ctlVal),
    .result(result), .flagsOut(flagsOut)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent reference: returns {result, flags}
  function automatic logic [24:0] model(input logic [2:0] op, input logic [15:0] a,
      input logic [15:0] b, input logic wd, input logic ci, input logic upd,
      input logic [8:0] old);
    int w, mask, am, bm, c, r, sa, sb, sr, cf, af, ofl, half;
    logic [15:0] res;
    logic [8:0] nf;
    w = wd ? 16 : 8;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    am = int'(a) & mask;
    bm = (op == DEC) ? 1 : (int'(b) & mask);
    c = (op == ADC || op == SBB) ? int'(ci) : 0;
    sa = (am >= half) ? am - (1 << w) : am;
    sb = (bm >= half) ? bm - (1 << w) : bm;
    cf = 0; af = int'(old[2]); ofl = 0; r = 0; sr = 0;
    case (op)
      ADD, ADC: begin
        r = am + bm + c; cf = (r > mask) ? 1 : 0;
        af = (((am & 15) + (bm & 15) + c) > 15) ? 1 : 0;
        sr = sa + sb + c;
      end
      SUB, SBB, DEC: begin
        r = am - bm - c; cf = (r < 0) ? 1 : 0;
        af = (((am & 15) - (bm & 15) - c) < 0) ? 1 : 0;
        sr = sa - sb - c;
      end
      AND_: r = am & bm;
      OR_:  r = am | bm;
      default: r = am ^ bm;
    endcase
    if (op == ADD || op == ADC || op == SUB || op == SBB || op == DEC)
      ofl = (sr > half - 1 || sr < -half) ? 1 : 0;
    res = 16'(r & mask);
    nf = old;
    nf[0] = cf[0];
    nf[1] = ~^res[7:0];
    nf[2] = af[0];
    nf[3] = (res == 16'h0);
    nf[4] = res[w-1];
    nf[5] = ofl[0];
    if (op == DEC || !upd) nf = old;
    return {res, nf};
  endfunction

  task automatic doOp(input string req, input logic [2:0] op, input logic [15:0] a,
      input logic [15:0] b, input logic wd, input logic ci, input logic upd);
    logic [24:0] m;
    @(negedge clk);
    opCode = op; opA = a; opB = b; wideMode = wd; carryIn = ci; updateEn = upd;
    ctlWr = 1'b0;
    m = model(op, a, b, wd, ci, upd, expFlags);
    #(CLK_P/4);
    chk({req, " result"}, {16'h0, result}, {16'h0, m[24:9]});
    @(posedge clk); #1;
    expFlags = m[8:0];
    chk({req, " flags"}, {23'h0, flagsOut}, {23'h0, expFlags});
    @(negedge clk);
    updateEn = 1'b0;
  endtask

  task automatic ctl(input string req, input logic [1:0] sel, input logic val);
    @(negedge clk);
    updateEn = 1'b0; ctlWr = 1'b1; ctlSel = sel; ctlVal = val;
    @(posedge clk); #1;
    if (sel != 2'd3) expFlags[6 + sel] = val;
    chk(req, {23'h0, flagsOut}, {23'h0, expFlags});
    @(negedge clk);
    ctlWr = 1'b0;
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    expFlags = '0;
    chk("R11 reset flags", {23'h0, flagsOut}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic testAddWord();
    doOp("R4 word 7FFF+1", ADD, 16'h7FFF, 16'h0001, 1'b1, 1'b0, 1'b1);
    doOp("R2 word FFFF+1", ADD, 16'hFFFF, 16'h0001, 1'b1, 1'b0, 1'b1);
    doOp("R3 word nibble carry", ADD, 16'h0008, 16'h0008, 1'b1, 1'b0, 1'b1);
    doOp("R1 add ignores carryIn", ADD, 16'h1234, 16'h1111, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic testAddByte();
    doOp("R4 byte 7F+1", ADD, 16'hAB7F, 16'h0001, 1'b0, 1'b0, 1'b1);
    doOp("R5 byte FF+1 zero", ADD, 16'h12FF, 16'h3401, 1'b0, 1'b0, 1'b1);
    doOp("R1 byte upper cleared", ADD, 16'hFF10, 16'hFF20, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testCarryChain();
    doOp("R2 adc with carry", ADC, 16'hFFFE, 16'h0001, 1'b1, 1'b1, 1'b1);
    doOp("R2 adc no carry", ADC, 16'h00FE, 16'h0001, 1'b0, 1'b0, 1'b1);
    doOp("R2 sbb with borrow", SBB, 16'h0005, 16'h0005, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic testSubtract();
    doOp("R2 word 0-1 borrow", SUB, 16'h0000, 16'h0001, 1'b1, 1'b0, 1'b1);
    doOp("R4 word 8000-1", SUB, 16'h8000, 16'h0001, 1'b1, 1'b0, 1'b1);
    doOp("R3 nibble borrow", SUB, 16'h0010, 16'h0001, 1'b1, 1'b0, 1'b1);
    doOp("R4 byte 80-1", SUB, 16'h0080, 16'h0001, 1'b0, 1'b0, 1'b1);
    doOp("R5 sub equal zero", SUB, 16'h5A5A, 16'h5A5A, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic testLogicOps();
    doOp("R3 set AF before logic", ADD, 16'h000F, 16'h0001, 1'b1, 1'b0, 1'b1);
    doOp("R7 and keeps AF", AND_, 16'hF0F0, 16'h8F00, 1'b1, 1'b0, 1'b1);
    doOp("R2 carry set", ADD, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1);
    doOp("R7 or clears CF", OR_, 16'h0003, 16'h8000, 1'b1, 1'b0, 1'b1);
    doOp("R7 xor byte zero", XOR_, 16'h12A5, 16'h34A5, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testCounterDec();
    doOp("R2 set flags", SUB, 16'h0000, 16'h0001, 1'b1, 1'b0, 1'b1);
    doOp("R8 dec keeps flags", DEC, 16'h0001, 16'h0000, 1'b1, 1'b0, 1'b1);
    doOp("R8 dec wraps", DEC, 16'h0000, 16'hFFFF, 1'b1, 1'b1, 1'b1);
    doOp("R8 dec byte", DEC, 16'h1200, 16'h0000, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testNoUpdate();
    doOp("R9 hold on no update", ADD, 16'h7FFF, 16'h0001, 1'b1, 1'b0, 1'b0);
    doOp("R9 hold logic no update", AND_, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testControlFlags();
    ctl("R10 set trap", 2'd0, 1'b1);
    ctl("R10 set intr", 2'd1, 1'b1);
    ctl("R10 set dir", 2'd2, 1'b1);
    ctl("R10 select none", 2'd3, 1'b0);
    doOp("R10 arith keeps control", SUB, 16'h0000, 16'h0001, 1'b1, 1'b0, 1'b1);
    doOp("R10 logic keeps control", XOR_, 16'h00FF, 16'h00FF, 1'b1, 1'b0, 1'b1);
    ctl("R10 clear intr", 2'd1, 1'b0);
    ctl("R10 clear trap", 2'd0, 1'b0);
  endtask

  task automatic testParityLowByte();
    doOp("R6 parity low byte only", ADD, 16'h00FF, 16'h0001, 1'b1, 1'b0, 1'b1);
    doOp("R6 odd low byte", ADD, 16'h0100, 16'h0001, 1'b1, 1'b0, 1'b1);
    doOp("R6 byte parity", OR_, 16'hFF03, 16'h0000, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    opA = '0; opB = '0; opCode = '0; wideMode = 1'b1; carryIn = 1'b0;
    updateEn = 1'b0; ctlWr = 1'b0; ctlSel = '0; ctlVal = 1'b0; rst_n = 1'b0;
    expFlags = '0;
    testReset();
    testAddWord();
    testAddByte();
    testCarryChain();
    testSubtract();
    testLogicOps();
    testCounterDec();
    testNoUpdate();
    testControlFlags();
    testParityLowByte();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule